// File: doc/BRIEF.md
# Hybrid Priority Round-Robin Bus Arbiter

This block decides which of four bus agents owns a shared bus. Three of them are ordinary agents: a processor, a graphics pipeline and a low-urgency display fetch. The fourth is an urgent display fetch. The urgent fetch takes the bus at every arbitration point. The three ordinary agents compete under a policy set by a single mode input. In rotating mode they share one priority level and take turns. In fixed mode the processor comes first, then graphics, then the low-urgency display.

A grant is registered and stays on until the owning agent pulses `xfer_done`. That edge is also the next arbitration point, so a new grant appears in the cycle after `xfer_done`. A transfer is never cut off in the middle. The mode input is only looked at on arbitration edges.

Top module: `hybrid_bus_arbiter`

## Requirements
- R1: While `rst` is high and after it falls, `grant` is 4'b0000 and `bus_busy` is 0. The rotation pointer starts at the processor, so the first rotating arbitration with all three ordinary agents requesting grants the processor.
- R2: Request bit 3 is the urgent display fetch. At any arbitration edge where `req[3]` is high, the next `grant` is 4'b1000, in both modes.
- R3: With `rotate_en` = 0 at an arbitration edge and `req[3]` low, the ordinary agents win in the order bit 0 (processor), then bit 1 (graphics), then bit 2 (low display).
- R4: With `rotate_en` = 1 at an arbitration edge and `req[3]` low, the winner is the first requesting ordinary agent found by scanning from the pointer in the cyclic order 0, 1, 2.
- R5: After an ordinary agent k is granted, in either mode, the pointer moves to (k+1) mod 3. A grant to the urgent agent, or an arbitration with no winner, leaves the pointer unchanged.
- R6: An arbitration edge is any rising clock edge where no grant is held, or where `xfer_done` is high. Between arbitration edges `grant` holds its value. A new grant becomes visible in the cycle after `xfer_done`. `bus_busy` is high exactly when `grant` is non-zero.
- R7: `grant` is one-hot or zero, and it is zero after an arbitration edge with no request. A newly issued grant only goes to an agent whose request was high at that arbitration edge. A dropped request does not end a held grant.
- R8: Changes to `rotate_en` while a grant is held have no effect on that grant. Only the value present at an arbitration edge selects the policy.
- R9: `xfer_done` asserted while no grant is held has no effect beyond an ordinary idle arbitration.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 4 | Requests: 0 processor, 1 graphics, 2 low display, 3 urgent display |
| xfer_done | input | 1 | Owning agent finishes its transfer this cycle |
| rotate_en | input | 1 | 1 = rotating policy among agents 0..2, 0 = fixed order |
| grant | output | 4 | Registered one-hot grant, zero when idle |
| bus_busy | output | 1 | High while a grant is held |

## Verification
The assertions check the cycle-level invariants on every cycle:
- the grant is one-hot or zero;
- the grant stays stable while a transfer is open;
- a new grant only goes to an agent that was requesting;
- the urgent fetch wins whenever it requests at an arbitration point;
- the latched mode stays frozen during a held grant;
- the pointer stays put when no ordinary agent wins.

The order of turn-taking over many transfers can only be shown by the bench's scenarios, which compare every cycle against a behavioural model. The same holds for the fixed ranking, for the pointer being skipped over by urgent grants, and for mode changes taking effect at the next boundary.

// File: rtl/arb_pkg.sv
package arb_pkg;
  typedef enum logic {
    MODE_FIXED  = 1'b0,
    MODE_ROTATE = 1'b1
  } arb_mode_e;
endpackage

// File: rtl/arb_fixed_pick.sv
module arb_fixed_pick #(
  parameter int N = 3
) (
  input  logic [N-1:0] req_i,
  output logic [N-1:0] pick_o
);
  always_comb begin
    pick_o = '0;
    for (int k = N - 1; k >= 0; k--) begin
      if (req_i[k]) begin
        pick_o    = '0;
        pick_o[k] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/arb_rr_pick.sv
module arb_rr_pick #(
  parameter int N  = 3,
  parameter int PW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req_i,
  input  logic [PW-1:0] ptr_i,
  output logic [N-1:0]  pick_o
);
  always_comb begin
    logic found;
    pick_o = '0;
    found  = 1'b0;
    for (int k = 0; k < N; k++) begin
      int idx;
      idx = (int'(ptr_i) + k) % N;
      if (!found && req_i[idx]) begin
        pick_o[idx] = 1'b1;
        found       = 1'b1;
      end
    end
  end
endmodule

// File: rtl/arb_rr_pointer.sv
module arb_rr_pointer #(
  parameter int N  = 3,
  parameter int PW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          adv_i,
  input  logic [PW-1:0] win_i,
  output logic [PW-1:0] ptr_o
);
  localparam logic [PW-1:0] LAST = PW'(N - 1);

  always_ff @(posedge clk) begin
    if (rst)        ptr_o <= '0;
    else if (adv_i) ptr_o <= (win_i == LAST) ? '0 : win_i + 1'b1;
  end

  // R5: pointer only moves when an ordinary agent wins
  a_r5_ptr_still: assert property (@(posedge clk) disable iff (rst)
    !adv_i |=> $stable(ptr_o));
  a_r5_ptr_range: assert property (@(posedge clk) disable iff (rst)
    ptr_o <= LAST);
endmodule

// File: rtl/hybrid_bus_arbiter.sv
module hybrid_bus_arbiter #(
  parameter int N_SHARED = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [N_SHARED:0]   req,
  input  logic                xfer_done,
  input  logic                rotate_en,
  output logic [N_SHARED:0]   grant,
  output logic                bus_busy
);
  import arb_pkg::*;

  localparam int NR = N_SHARED + 1;
  localparam int HI = N_SHARED;
  localparam int PW = (N_SHARED > 1) ? $clog2(N_SHARED) : 1;

  logic [NR-1:0]       gnt_q;
  logic                busy_q;
  arb_mode_e           mode_q;
  logic [N_SHARED-1:0] sh_req, fix_pick, rr_pick, sh_pick;
  logic [NR-1:0]       pick;
  logic [PW-1:0]       ptr, win_idx;
  logic                arb_now, adv;

  assign sh_req  = req[N_SHARED-1:0];
  assign arb_now = !busy_q || xfer_done;

  arb_fixed_pick #(.N(N_SHARED)) u_fix (
    .req_i (sh_req),
    .pick_o(fix_pick)
  );

  arb_rr_pick #(.N(N_SHARED), .PW(PW)) u_rr (
    .req_i (sh_req),
    .ptr_i (ptr),
    .pick_o(rr_pick)
  );

  always_comb begin
    sh_pick = rotate_en ? rr_pick : fix_pick;
    pick    = '0;
    if (req[HI]) pick[HI] = 1'b1;
    else         pick[N_SHARED-1:0] = sh_pick;
  end

  always_comb begin
    win_idx = '0;
    for (int k = 0; k < N_SHARED; k++) begin
      if (pick[k]) win_idx = k[PW-1:0];
    end
  end

  assign adv = arb_now && !req[HI] && (|sh_pick);

  arb_rr_pointer #(.N(N_SHARED), .PW(PW)) u_ptr (
    .clk  (clk),
    .rst  (rst),
    .adv_i(adv),
    .win_i(win_idx),
    .ptr_o(ptr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      gnt_q  <= '0;
      busy_q <= 1'b0;
      mode_q <= MODE_FIXED;
    end else if (arb_now) begin
      gnt_q  <= pick;
      busy_q <= |pick;
      mode_q <= rotate_en ? MODE_ROTATE : MODE_FIXED;
    end
  end

  assign grant    = gnt_q;
  assign bus_busy = busy_q;

  // R7: grant is one-hot or zero
  a_r7_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant));
  // R6: grant held while a transfer is open
  a_r6_hold: assert property (@(posedge clk) disable iff (rst)
    bus_busy && !xfer_done |=> $stable(grant));
  // R7: new grant only to an agent requesting at the boundary
  a_r7_req_only: assert property (@(posedge clk) disable iff (rst)
    (!bus_busy || xfer_done) |=> ((grant & ~$past(req)) == '0));
  // R2: urgent request wins at every boundary
  a_r2_urgent: assert property (@(posedge clk) disable iff (rst)
    (!bus_busy || xfer_done) && req[HI] |=> grant[HI]);
  // R8: latched mode frozen during a held grant
  a_r8_mode_frozen: assert property (@(posedge clk) disable iff (rst)
    bus_busy && !xfer_done |=> $stable(mode_q));
endmodule

// File: tb/hybrid_bus_arbiter_tb.sv
module hybrid_bus_arbiter_tb;
  logic       clk = 1'b0;
  logic       rst;
  logic [3:0] req;
  logic       xfer_done;
  logic       rotate_en;
  logic [3:0] grant;
  logic       bus_busy;

  int n_chk  = 0;
  int n_fail = 0;
  int exp_g  = -1;
  int exp_ptr = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #5 clk = ~clk;

  hybrid_bus_arbiter u_dut (
    .clk(clk), .rst(rst), .req(req), .xfer_done(xfer_done),
    .rotate_en(rotate_en), .grant(grant), .bus_busy(bus_busy)
  );

  task automatic check(input string tag);
    logic [3:0] eg;
    logic       eb;
    eg = (exp_g < 0) ? 4'b0000 : 4'(1 << exp_g);
    eb = (exp_g >= 0);
    n_chk++;
    if (grant !== eg || bus_busy !== eb) begin
      n_fail++;
      $display("FAIL %s: grant=%b busy=%b expected grant=%b busy=%b",
               tag, grant, bus_busy, eg, eb);
    end
  endtask

  // behavioural model of one clock edge
  task automatic model(input logic [3:0] r, input logic d, input logic m);
    int w;
    if (exp_g < 0 || d) begin
      w = -1;
      if (r[3]) w = 3;
      else if (m) begin
        for (int k = 0; k < 3; k++)
          if (w < 0 && r[(exp_ptr + k) % 3]) w = (exp_ptr + k) % 3;
      end else begin
        for (int k = 2; k >= 0; k--)
          if (r[k]) w = k;
      end
      if (w >= 0 && w < 3) exp_ptr = (w + 1) % 3;
      exp_g = w;
    end
  endtask

  task automatic step(input logic [3:0] r, input logic d, input logic m,
                      input string tag);
    req = r; xfer_done = d; rotate_en = m;
    model(r, d, m);
    @(posedge clk);
    @(negedge clk);
    check(tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst = 1'b1; req = 4'b1111; xfer_done = 1'b0; rotate_en = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 grant idle in reset");
    rst = 1'b0;
    // R9: done while idle, no request
    step(4'b0000, 1'b1, 1'b1, "R9 done while idle");
    // R1: pointer starts at processor
    step(4'b0111, 1'b0, 1'b1, "R1 first rotate grant to processor");
    // R4 rotation
    step(4'b0111, 1'b1, 1'b1, "R4 rotate to graphics");
    step(4'b0111, 1'b1, 1'b1, "R4 rotate to low display");
    step(4'b0111, 1'b1, 1'b1, "R4 rotate wraps to processor");
    // R6 hold with dropped request; R7 dropped request keeps grant
    step(4'b0110, 1'b0, 1'b1, "R6 grant held after request drop");
    // R8 mode flip mid-transfer
    step(4'b0111, 1'b0, 1'b0, "R8 mode change ignored during grant");
    // R2 urgent in rotate mode; R5 pointer untouched by it
    step(4'b1111, 1'b1, 1'b1, "R2 urgent wins in rotate mode");
    step(4'b0111, 1'b1, 1'b1, "R5 pointer unchanged by urgent grant");
    // R3 fixed order
    step(4'b0110, 1'b1, 1'b0, "R3 graphics above low display");
    step(4'b0111, 1'b1, 1'b0, "R3 processor first");
    step(4'b0111, 1'b1, 1'b0, "R3 processor again in fixed mode");
    step(4'b0100, 1'b1, 1'b0, "R3 low display alone");
    step(4'b1001, 1'b1, 1'b0, "R2 urgent wins in fixed mode");
    step(4'b0000, 1'b1, 1'b0, "R7 zero grant with no request");
    step(4'b0000, 1'b0, 1'b0, "R7 stays idle");
    // R8: mode at boundary selects policy
    step(4'b0111, 1'b0, 1'b1, "R8 rotate mode chosen at boundary");
    step(4'b0111, 1'b1, 1'b0, "R8 fixed mode chosen at boundary");
    // pseudo-random traffic
    for (int i = 0; i < 600; i++) begin
      logic [3:0] r;
      logic d, m;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      r = lfsr[3:0] & {lfsr[9] & lfsr[8], 3'b111};
      d = lfsr[5] | lfsr[11];
      m = lfsr[7] ^ lfsr[14];
      step(r, d, m, "R6/R7 random traffic");
    end
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule